// File: doc/BRIEF.md
# Thermostat Over-Limit Alarm with Consecutive-Fault Filter

This block turns a stream of signed 9-bit temperature samples (two's complement, 0.5 °C per LSB) into an over-limit alarm pin. Each sample is compared against an upper trip limit and a lower release limit. The samples only count toward an event when enough of them in a row meet the condition being watched. The required run length is chosen by a 2-bit depth code.

There are two ways to operate the block. In thermostat (comparator) mode the pin follows the temperature with hysteresis. In latched (interrupt) mode an event raises the alarm, and the alarm then holds until software reads any register or shutdown is entered. The watched condition alternates between the upper limit and the lower limit from one event to the next. A polarity input picks whether the active level of the pin is low or high. The sensor converter and the serial bus sit outside this block. They supply the sample strobe, the register-read strobe and the configuration bits.

Top module: `ovt_alarm`

## Requirements
- R1: While and after reset the alarm is inactive. With polarity 0 the pin then reads 1.
- R2: The depth code `cfgQueue` sets how many consecutive qualifying samples form an event: 0 needs 1, 1 needs 2, 2 needs 4, 3 needs 6. A sample qualifies as hot when it is strictly greater than `limitHigh`.
- R3: While a run is being counted, a sample that does not meet the watched condition resets the run to zero.
- R4: In thermostat mode, an active alarm goes inactive after the configured number of consecutive samples strictly below `limitLow`. A sample equal to `limitLow`, or one lying between the two limits, breaks that run.
- R5: In thermostat mode, register reads and shutdown entry leave the alarm unchanged.
- R6: In latched mode (`cfgIntMode`=1) a hot event activates the alarm. It stays active, whatever the later samples are, until a read strobe or a 0-to-1 transition of `cfgShutdown` clears it.
- R7: In latched mode, once an alarm raised by a hot event has been cleared, the next event is a run of samples below `limitLow`. That event activates the alarm again, and after it is cleared the block watches the upper limit again, alternating in this way.
- R8: All comparisons treat samples and limits as signed two's complement. For example, a sample of 0x000 exceeds a limit of 0x1CE (−25 °C).
- R9: The pin equals the active flag when `cfgPolarity`=1 and its inverse when `cfgPolarity`=0. A change of polarity reaches the pin in the same cycle, with no clock edge in between.
- R10: A change of `cfgIntMode` clears the run, deactivates the alarm and returns the block to watching the upper limit.
- R11: Cycles without `sampleValid`, such as those during shutdown, leave a partial run unchanged.
- R12: A sample or read that causes a state change takes effect at the clock edge where it is sampled. The pin shows the new state after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | One-cycle strobe: a new sample is present |
| sampleTemp | input | TEMP_W | Sample, signed, 0.5 °C per LSB |
| limitHigh | input | TEMP_W | Upper trip limit (top bits of the trip register) |
| limitLow | input | TEMP_W | Lower release limit (top bits of the hysteresis register) |
| cfgQueue | input | 2 | Consecutive-fault depth code |
| cfgPolarity | input | 1 | 1 = active-high pin, 0 = active-low pin |
| cfgIntMode | input | 1 | 0 = thermostat mode, 1 = latched mode |
| cfgShutdown | input | 1 | Shutdown control level; its rising edge is shutdown entry |
| regReadStb | input | 1 | One-cycle strobe: some register was read |
| alarmPin | output | 1 | Alarm pin level |

## Verification
The alarm state is one register deep. A sample, read or shutdown entry presented before edge k is therefore visible on the pin just after edge k, while a polarity change shows up at once, without waiting for an edge. A behavioural model in the bench advances at every rising edge from the same inputs. The bench then compares the pin a short delay after that edge, while inputs change only on falling edges. Directed checks follow the same rule: one test samples the pin just before and just after the triggering edge to pin down that single-cycle latency, and the polarity test samples between edges.

// File: rtl/ovt_pkg.sv
package ovt_pkg;

  // Watch phase: ARM_* counts toward an event, FLAG_* holds a latched alarm.
  typedef enum logic [1:0] {
    ARM_HI  = 2'd0,
    FLAG_HI = 2'd1,
    ARM_LO  = 2'd2,
    FLAG_LO = 2'd3
  } phase_e;

  // Strobes from control to the counting datapath.
  typedef struct packed {
    logic countEn;     // samples may advance the run
    logic watchLow;    // 1: count samples below limitLow, 0: above limitHigh
    logic clearCount;  // drop the run to zero this cycle
  } queue_ctrl_t;

endpackage

// File: rtl/ovt_queue.sv
module ovt_queue
  import ovt_pkg::*;
#(
  parameter int TEMP_W  = 9,
  parameter int DEPTH_0 = 1,
  parameter int DEPTH_1 = 2,
  parameter int DEPTH_2 = 4,
  parameter int DEPTH_3 = 6,
  parameter int MAX_D   = 6,
  parameter int CNT_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleTemp,
  input  logic [TEMP_W-1:0] limitHigh,
  input  logic [TEMP_W-1:0] limitLow,
  input  logic [1:0]        cfgQueue,
  input  queue_ctrl_t       ctrl,
  output logic              queueHit
);

  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] runNext;
  logic             overHigh;
  logic             underLow;
  logic             qualifies;

  always_comb begin
    unique case (cfgQueue)
      2'd0:    need = CNT_W'(DEPTH_0);
      2'd1:    need = CNT_W'(DEPTH_1);
      2'd2:    need = CNT_W'(DEPTH_2);
      default: need = CNT_W'(DEPTH_3);
    endcase
  end

  assign overHigh  = $signed(sampleTemp) > $signed(limitHigh);
  assign underLow  = $signed(sampleTemp) < $signed(limitLow);
  assign qualifies = ctrl.watchLow ? underLow : overHigh;
  assign queueHit  = sampleValid && ctrl.countEn && qualifies &&
                     ((runCnt + CNT_W'(1)) >= need);

  always_comb begin
    runNext = runCnt;
    if (sampleValid && ctrl.countEn) begin
      if (!qualifies || queueHit) runNext = '0;
      else                        runNext = runCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                runCnt <= '0;
    else if (ctrl.clearCount) runCnt <= '0;
    else                      runCnt <= runNext;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < CNT_W'(MAX_D));

  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && !ctrl.clearCount) |=> $stable(runCnt));

endmodule

// File: rtl/ovt_fsm.sv
module ovt_fsm
  import ovt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgIntMode,
  input  logic        cfgShutdown,
  input  logic        regReadStb,
  input  logic        queueHit,
  output queue_ctrl_t ctrl,
  output logic        alarmActive
);

  phase_e phaseQ, phaseD;
  logic   activeQ, activeD;
  logic   prevMode, prevSd;
  logic   modeFlip, sdEntry, clearReq, flagged;

  assign modeFlip = cfgIntMode ^ prevMode;
  assign sdEntry  = cfgShutdown & ~prevSd;
  assign clearReq = cfgIntMode & (regReadStb | sdEntry);
  assign flagged  = (phaseQ == FLAG_HI) || (phaseQ == FLAG_LO);

  assign ctrl.countEn    = !flagged;
  assign ctrl.watchLow   = (phaseQ == ARM_LO);
  assign ctrl.clearCount = modeFlip || (flagged && clearReq);

  always_comb begin
    phaseD  = phaseQ;
    activeD = activeQ;
    if (modeFlip) begin
      phaseD  = ARM_HI;
      activeD = 1'b0;
    end else if (flagged && clearReq) begin
      phaseD  = (phaseQ == FLAG_HI) ? ARM_LO : ARM_HI;
      activeD = 1'b0;
    end else if (queueHit) begin
      if (cfgIntMode) begin
        phaseD  = (phaseQ == ARM_HI) ? FLAG_HI : FLAG_LO;
        activeD = 1'b1;
      end else begin
        phaseD  = (phaseQ == ARM_HI) ? ARM_LO : ARM_HI;
        activeD = (phaseQ == ARM_HI);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= ARM_HI;
      activeQ  <= 1'b0;
      prevMode <= 1'b0;
      prevSd   <= 1'b0;
    end else begin
      phaseQ   <= phaseD;
      activeQ  <= activeD;
      prevMode <= cfgIntMode;
      prevSd   <= cfgShutdown;
    end
  end

  assign alarmActive = activeQ;

  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!queueHit && !clearReq && !modeFlip) |=> $stable(activeQ));

  // R6
  int_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIntMode && flagged && (regReadStb || sdEntry) && !modeFlip) |=> !activeQ);

  // R4
  cmp_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgIntMode && !modeFlip) |-> (activeQ == (phaseQ == ARM_LO)));

  // R10
  mode_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeFlip |=> (!activeQ && phaseQ == ARM_HI));

endmodule

// File: rtl/ovt_alarm.sv
module ovt_alarm
  import ovt_pkg::*;
#(
  parameter int TEMP_W  = 9,
  parameter int DEPTH_0 = 1,
  parameter int DEPTH_1 = 2,
  parameter int DEPTH_2 = 4,
  parameter int DEPTH_3 = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleTemp,
  input  logic [TEMP_W-1:0] limitHigh,
  input  logic [TEMP_W-1:0] limitLow,
  input  logic [1:0]        cfgQueue,
  input  logic              cfgPolarity,
  input  logic              cfgIntMode,
  input  logic              cfgShutdown,
  input  logic              regReadStb,
  output logic              alarmPin
);

  localparam int MAX_01 = (DEPTH_0 > DEPTH_1) ? DEPTH_0 : DEPTH_1;
  localparam int MAX_23 = (DEPTH_2 > DEPTH_3) ? DEPTH_2 : DEPTH_3;
  localparam int MAX_D  = (MAX_01 > MAX_23) ? MAX_01 : MAX_23;
  localparam int CNT_W  = $clog2(MAX_D + 1);

  queue_ctrl_t qCtrl;
  logic        queueHit;
  logic        alarmActive;

  ovt_queue #(
    .TEMP_W(TEMP_W), .DEPTH_0(DEPTH_0), .DEPTH_1(DEPTH_1),
    .DEPTH_2(DEPTH_2), .DEPTH_3(DEPTH_3), .MAX_D(MAX_D), .CNT_W(CNT_W)
  ) queue_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleTemp(sampleTemp),
    .limitHigh(limitHigh), .limitLow(limitLow), .cfgQueue(cfgQueue),
    .ctrl(qCtrl), .queueHit(queueHit)
  );

  ovt_fsm fsm_i (
    .clk(clk), .rstN(rstN), .cfgIntMode(cfgIntMode), .cfgShutdown(cfgShutdown),
    .regReadStb(regReadStb), .queueHit(queueHit), .ctrl(qCtrl),
    .alarmActive(alarmActive)
  );

  assign alarmPin = cfgPolarity ? alarmActive : ~alarmActive;

endmodule

// File: tb/ovt_alarm_tb_top.sv
module ovt_alarm_tb_top;

  localparam logic [8:0] HOT  = 9'h0A1;
  localparam logic [8:0] COLD = 9'h095;
  localparam logic [8:0] MID  = 9'h098;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleValid = 1'b0;
  logic [8:0] sampleTemp = '0;
  logic [8:0] limitHigh = 9'h0A0;
  logic [8:0] limitLow = 9'h096;
  logic [1:0] cfgQueue = 2'd0;
  logic       cfgPolarity = 1'b0;
  logic       cfgIntMode = 1'b0;
  logic       cfgShutdown = 1'b0;
  logic       regReadStb = 1'b0;
  logic       alarmPin;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string curReq = "R1";

  // behavioural reference state
  int run;
  bit lookLow, latched, act, lastMode, lastSd;

  always #4 clk = ~clk;

  ovt_alarm dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleTemp(sampleTemp),
    .limitHigh(limitHigh), .limitLow(limitLow), .cfgQueue(cfgQueue),
    .cfgPolarity(cfgPolarity), .cfgIntMode(cfgIntMode), .cfgShutdown(cfgShutdown),
    .regReadStb(regReadStb), .alarmPin(alarmPin)
  );

  function automatic int depthOf(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic bit pinFor(input bit a);
    return cfgPolarity ? a : !a;
  endfunction

  always @(posedge clk) begin
    bit modeChanged, sdEnter, cond;
    if (!rstN) begin
      run = 0; lookLow = 0; latched = 0; act = 0; lastMode = 0; lastSd = 0;
    end else begin
      modeChanged = (cfgIntMode != lastMode);
      sdEnter     = cfgShutdown && !lastSd;
      lastMode    = cfgIntMode;
      lastSd      = cfgShutdown;
      if (modeChanged) begin
        run = 0; lookLow = 0; latched = 0; act = 0;
      end else if (cfgIntMode && latched && (regReadStb || sdEnter)) begin
        latched = 0; act = 0; run = 0;
      end else if (!latched && sampleValid) begin
        cond = lookLow ? ($signed(sampleTemp) < $signed(limitLow))
                       : ($signed(sampleTemp) > $signed(limitHigh));
        run = cond ? run + 1 : 0;
        if (run >= depthOf(cfgQueue)) begin
          run = 0;
          if (cfgIntMode) begin latched = 1; act = 1; end
          else act = !lookLow;
          lookLow = !lookLow;
        end
      end
    end
    #2;
    checks++;
    if (alarmPin !== pinFor(act)) begin
      errors++;
      $display("FAIL %s (model) pin=%0b expected=%0b at cycle %0d", curReq, alarmPin, pinFor(act), cyc);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic expectAct(input string req, input bit a);
    checks++;
    if (alarmPin !== pinFor(a)) begin
      errors++;
      $display("FAIL %s pin=%0b expected=%0b", req, alarmPin, pinFor(a));
    end
  endtask

  task automatic feed(input logic [8:0] t);
    @(negedge clk);
    sampleValid = 1'b1; sampleTemp = t;
    @(posedge clk); #2;
    sampleValid = 1'b0;
  endtask

  task automatic feedN(input logic [8:0] t, input int n);
    for (int i = 0; i < n; i++) feed(t);
  endtask

  task automatic pulseRead();
    @(negedge clk);
    regReadStb = 1'b1;
    @(posedge clk); #2;
    regReadStb = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  initial begin
    tick(3);
    curReq = "R1";
    checks++;
    if (alarmPin !== 1'b1) begin errors++; $display("FAIL R1 pin=%0b expected=1", alarmPin); end
    @(negedge clk); rstN = 1'b1;
    tick(2);
    expectAct("R1", 0);

    // R2 / R4: every depth code, on and off
    for (int f = 0; f < 4; f++) begin
      curReq = "R2";
      cfgQueue = 2'(f);
      feedN(HOT, depthOf(2'(f)) - 1);
      expectAct("R2", 0);
      feed(HOT);
      expectAct("R2", 1);
      curReq = "R4";
      feedN(COLD, depthOf(2'(f)) - 1);
      expectAct("R4", 1);
      feed(COLD);
      expectAct("R4", 0);
    end

    // R3: a broken run restarts
    curReq = "R3";
    cfgQueue = 2'd2;
    feedN(HOT, 3); feed(MID); feedN(HOT, 3);
    expectAct("R3", 0);
    feed(HOT);
    expectAct("R3", 1);
    feedN(COLD, 4);
    expectAct("R3", 0);

    // R4: equal-to-limit and between-limits samples break the release run
    curReq = "R4";
    cfgQueue = 2'd0; feed(HOT);
    cfgQueue = 2'd1;
    feedN(9'h096, 3); feed(COLD); feed(MID); feed(COLD);
    expectAct("R4", 1);
    feedN(COLD, 2);
    expectAct("R4", 0);

    // R5: reads and shutdown entry in thermostat mode
    curReq = "R5";
    cfgQueue = 2'd0; feed(HOT);
    pulseRead();
    expectAct("R5", 1);
    @(negedge clk); cfgShutdown = 1'b1;
    tick(3);
    expectAct("R5", 1);
    @(negedge clk); cfgShutdown = 1'b0;
    feed(COLD);
    expectAct("R5", 0);

    // R8: signed limits
    curReq = "R8";
    limitHigh = 9'h1CE; limitLow = 9'h1B0;
    feed(9'h000);
    expectAct("R8", 1);
    feed(9'h0FA);
    expectAct("R8", 1);
    feed(9'h1A0);
    expectAct("R8", 0);
    feed(9'h1CE);
    expectAct("R8", 0);
    limitHigh = 9'h0A0; limitLow = 9'h096;

    // R9: polarity reaches the pin without a clock edge
    curReq = "R9";
    @(negedge clk); cfgPolarity = 1'b1; #1;
    checks++;
    if (alarmPin !== 1'b0) begin errors++; $display("FAIL R9 pin=%0b expected=0", alarmPin); end
    feed(HOT);
    checks++;
    if (alarmPin !== 1'b1) begin errors++; $display("FAIL R9 pin=%0b expected=1", alarmPin); end
    @(negedge clk); cfgPolarity = 1'b0; #1;
    checks++;
    if (alarmPin !== 1'b0) begin errors++; $display("FAIL R9 pin=%0b expected=0", alarmPin); end
    feed(COLD);

    // R6 / R7: latched mode with alternating events
    curReq = "R6";
    @(negedge clk); cfgIntMode = 1'b1;
    cfgQueue = 2'd1;
    feed(HOT);
    expectAct("R6", 0);
    feed(HOT);
    expectAct("R6", 1);
    feedN(HOT, 2); feed(COLD);
    expectAct("R6", 1);
    pulseRead();
    expectAct("R6", 0);
    curReq = "R7";
    feedN(HOT, 3);
    expectAct("R7", 0);
    feed(COLD);
    expectAct("R7", 0);
    feed(COLD);
    expectAct("R7", 1);
    pulseRead();
    expectAct("R7", 0);
    feedN(COLD, 2);
    expectAct("R7", 0);
    feedN(HOT, 2);
    expectAct("R7", 1);
    curReq = "R6";
    @(negedge clk); cfgShutdown = 1'b1;
    @(posedge clk); #2;
    expectAct("R6", 0);
    @(negedge clk); cfgShutdown = 1'b0;

    // R10: mode change resets to watching the upper limit
    curReq = "R10";
    feed(COLD);
    @(negedge clk); cfgIntMode = 1'b0;
    feedN(COLD, 2);
    expectAct("R10", 0);
    feed(HOT);
    expectAct("R10", 0);
    feed(HOT);
    expectAct("R10", 1);
    feedN(COLD, 2);
    expectAct("R10", 0);
    @(negedge clk); cfgIntMode = 1'b1;
    feedN(HOT, 2);
    expectAct("R10", 1);
    @(negedge clk); cfgIntMode = 1'b0;
    @(posedge clk); #2;
    expectAct("R10", 0);

    // R11: partial run survives idle shutdown cycles
    curReq = "R11";
    cfgQueue = 2'd2;
    feedN(HOT, 2);
    @(negedge clk); cfgShutdown = 1'b1;
    tick(5);
    @(negedge clk); cfgShutdown = 1'b0;
    feed(HOT);
    expectAct("R11", 0);
    feed(HOT);
    expectAct("R11", 1);
    feedN(COLD, 4);

    // R12: pin changes at the sampling edge, not before
    curReq = "R12";
    cfgQueue = 2'd0;
    @(negedge clk); sampleValid = 1'b1; sampleTemp = HOT;
    #3;
    expectAct("R12", 0);
    @(posedge clk); #2;
    sampleValid = 1'b0;
    expectAct("R12", 1);
    feed(COLD);
    expectAct("R12", 0);

    tick(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule